// File: doc/BRIEF.md
# Display RAM Address Pointer Controller

This block owns the column and page pointers of a monochrome graphic display memory that is 128 columns wide and 8 pages tall. Each page is a strip of 8 pixel rows, and one byte stores one column of one page. A decoded stream of command bytes selects how the pointers move, sets the column and page window, and places the pointers directly. A separate stream of data bytes writes or reads the memory. After each data access, the pointers advance by the rule of the active mode.

The 1024-byte memory is held inside the block. The current address and the write strobe are also driven out so that a neighbour can follow the traffic. A pixel lookup port returns the state of any single pixel, addressed by row and column. This exposes how the bits of a stored byte map onto display rows.

Top module: `dram_ptr_ctrl`

## Requirements
- R1: After reset, the column pointer is 0, the page pointer is 0 and `addr_mode` reads 2'b10 (page mode). The column window is 0..127 and the page window is 0..7.
- R2: In page mode (2'b10), each data access adds 1 to the column. When the column equals the column end, it returns to the column start instead. The page never changes on an access in this mode.
- R3: In horizontal mode (2'b00), each access adds 1 to the column. When the column equals the column end, the column returns to the column start and the page advances by 1. When the page also equals the page end, the page returns to the page start.
- R4: In vertical mode (2'b01), each access adds 1 to the page. When the page equals the page end, the page returns to the page start and the column advances by 1. When the column also equals the column end, the column returns to the column start.
- R5: Command 20h followed by one argument byte selects the mode from the argument's bits 1:0, using the encoding 00 horizontal, 01 vertical, 10 page. The value 11 leaves the previous mode in place.
- R6: In page mode only, three command groups place the pointers. Commands B0h..B7h set the page to bits 2:0 of the command. Commands 00h..0Fh set column bits 3:0 to bits 3:0 of the command. Commands 10h..1Fh set column bits 6:4 to bits 2:0 of the command. In the other modes these commands have no effect.
- R7: Command 21h takes two argument bytes, the column start and then the column end. Command 22h takes two argument bytes, the page start and then the page end. When the second argument arrives, the matching pointer is loaded with the new start.
- R8: While argument bytes of 20h, 21h or 22h are pending, every command byte is taken as an argument, even one that would otherwise be a command.
- R9: A data write raises `ram_we` in the same cycle, with `ram_addr` = {page, column}. The byte is stored there and the pointers advance on that clock edge. A data read returns the byte at the current address on `rd_byte` one cycle later and also advances the pointers.
- R10: `pix_on` is bit (`pix_row` mod 8) of the byte stored at page `pix_row`/8 and column `pix_col`. Bit 0 is the top row of a page and bit 7 is the bottom row.
- R11: When `cmd_valid` and a data request arrive in the same cycle, the command is processed and the data request is ignored. A write has priority over a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command or argument byte present |
| cmd_byte | input | 8 | Command or argument value |
| wr_valid | input | 1 | Data write request |
| wr_byte | input | 8 | Data to store |
| rd_valid | input | 1 | Data read request |
| rd_byte | output | 8 | Read data, one cycle after the request |
| ram_we | output | 1 | Write strobe to the display memory |
| ram_addr | output | 10 | Current address {page, column} |
| col_ptr | output | 7 | Current column pointer |
| page_ptr | output | 3 | Current page pointer |
| addr_mode | output | 2 | Active pointer-advance mode |
| pix_row | input | 6 | Pixel lookup row |
| pix_col | input | 7 | Pixel lookup column |
| pix_on | output | 1 | Pixel lookup result |

## Verification
The bench builds the block with its default geometry of 128 columns and 8 pages. With that geometry, the top window values 7Fh and 07h and the full range of the nibble commands can be reached, and a wrap at column 127 can be observed. Narrow windows at the far corner of the memory make each mode's double wrap happen within a few accesses. Stored bytes are read back through the data path and through the pixel port.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    typedef enum logic [1:0] {
        AM_HORZ = 2'b00,
        AM_VERT = 2'b01,
        AM_PAGE = 2'b10,
        AM_BAD  = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ARG_NONE,
        ARG_MODE,
        ARG_COL,
        ARG_PAGE
    } argkind_e;

    localparam logic [7:0] OP_MODE   = 8'h20;
    localparam logic [7:0] OP_COLWIN = 8'h21;
    localparam logic [7:0] OP_PGWIN  = 8'h22;

    typedef struct packed {
        logic set_lo;
        logic set_hi;
        logic set_pg;
        logic win_col;
        logic win_pg;
    } ptr_req_t;

    function automatic logic is_col_lo(input logic [7:0] b);
        return b[7:4] == 4'h0;
    endfunction

    function automatic logic is_col_hi(input logic [7:0] b);
        return b[7:4] == 4'h1;
    endfunction

    function automatic logic is_pg_set(input logic [7:0] b);
        return b[7:3] == 5'b10110;
    endfunction

endpackage

// File: rtl/dptr_cmd_parser.sv
module dptr_cmd_parser
    import dptr_pkg::*;
#(
    parameter int COL_W    = 7,
    parameter int PAGE_W   = 3,
    parameter int COL_MAX  = 127,
    parameter int PAGE_MAX = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    output amode_e            mode,
    output logic [COL_W-1:0]  col_start,
    output logic [COL_W-1:0]  col_end,
    output logic [PAGE_W-1:0] page_start,
    output logic [PAGE_W-1:0] page_end,
    output ptr_req_t          req,
    output logic [COL_W-1:0]  ld_col_val,
    output logic [PAGE_W-1:0] ld_pg_val
);

    logic [1:0]       pend_cnt;
    argkind_e         pend_kind;
    logic [COL_W-1:0] arg_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt   <= 2'd0;
            pend_kind  <= ARG_NONE;
            mode       <= AM_PAGE;
            col_start  <= '0;
            col_end    <= COL_W'(COL_MAX);
            page_start <= '0;
            page_end   <= PAGE_W'(PAGE_MAX);
            arg_hold   <= '0;
        end else if (cmd_valid) begin
            if (pend_cnt != 2'd0) begin
                pend_cnt <= pend_cnt - 2'd1;
                if (pend_cnt == 2'd1) pend_kind <= ARG_NONE;
                case (pend_kind)
                    ARG_MODE: begin
                        if (cmd_byte[1:0] != 2'b11) mode <= amode_e'(cmd_byte[1:0]);
                    end
                    ARG_COL: begin
                        if (pend_cnt == 2'd2) arg_hold <= cmd_byte[COL_W-1:0];
                        else begin
                            col_start <= arg_hold;
                            col_end   <= cmd_byte[COL_W-1:0];
                        end
                    end
                    ARG_PAGE: begin
                        if (pend_cnt == 2'd2) arg_hold <= cmd_byte[COL_W-1:0];
                        else begin
                            page_start <= arg_hold[PAGE_W-1:0];
                            page_end   <= cmd_byte[PAGE_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end else begin
                case (cmd_byte)
                    OP_MODE:   begin pend_cnt <= 2'd1; pend_kind <= ARG_MODE; end
                    OP_COLWIN: begin pend_cnt <= 2'd2; pend_kind <= ARG_COL;  end
                    OP_PGWIN:  begin pend_cnt <= 2'd2; pend_kind <= ARG_PAGE; end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        req = '0;
        if (cmd_valid) begin
            if (pend_cnt != 2'd0) begin
                req.win_col = (pend_kind == ARG_COL)  && (pend_cnt == 2'd1);
                req.win_pg  = (pend_kind == ARG_PAGE) && (pend_cnt == 2'd1);
            end else if (mode == AM_PAGE) begin
                req.set_lo = is_col_lo(cmd_byte);
                req.set_hi = is_col_hi(cmd_byte);
                req.set_pg = is_pg_set(cmd_byte);
            end
        end
    end

    assign ld_col_val = arg_hold;
    assign ld_pg_val  = arg_hold[PAGE_W-1:0];

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= 2'd2);

    // R8
    arg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && pend_cnt == 2'd0 && cmd_byte == OP_COLWIN) |=> (pend_cnt == 2'd2));

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode != AM_BAD);

endmodule

// File: rtl/dptr_ptr_unit.sv
module dptr_ptr_unit
    import dptr_pkg::*;
#(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  amode_e            mode,
    input  logic [COL_W-1:0]  col_start,
    input  logic [COL_W-1:0]  col_end,
    input  logic [PAGE_W-1:0] page_start,
    input  logic [PAGE_W-1:0] page_end,
    input  ptr_req_t          req,
    input  logic [3:0]        nib,
    input  logic [PAGE_W-1:0] pg_sel,
    input  logic [COL_W-1:0]  ld_col_val,
    input  logic [PAGE_W-1:0] ld_pg_val,
    input  logic              step,
    output logic [COL_W-1:0]  col,
    output logic [PAGE_W-1:0] page
);

    logic [COL_W-1:0]  col_n, col_inc;
    logic [PAGE_W-1:0] pg_n, pg_inc;
    logic              col_last, pg_last;

    assign col_inc  = col + COL_W'(1);
    assign pg_inc   = page + PAGE_W'(1);
    assign col_last = (col == col_end);
    assign pg_last  = (page == page_end);

    always_comb begin
        col_n = col;
        pg_n  = page;
        if (req.win_col) col_n = ld_col_val;
        if (req.win_pg)  pg_n  = ld_pg_val;
        if (req.set_lo)  col_n = {col[COL_W-1:4], nib};
        if (req.set_hi)  col_n = COL_W'({nib, col[3:0]});
        if (req.set_pg)  pg_n  = pg_sel;
        if (step) begin
            case (mode)
                AM_PAGE: col_n = col_last ? col_start : col_inc;
                AM_HORZ: begin
                    if (col_last) begin
                        col_n = col_start;
                        pg_n  = pg_last ? page_start : pg_inc;
                    end else begin
                        col_n = col_inc;
                    end
                end
                AM_VERT: begin
                    if (pg_last) begin
                        pg_n  = page_start;
                        col_n = col_last ? col_start : col_inc;
                    end else begin
                        pg_n = pg_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col  <= '0;
            page <= '0;
        end else begin
            col  <= col_n;
            page <= pg_n;
        end
    end

    // R2
    page_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == AM_PAGE && !col_last) |=> (col == $past(col) + COL_W'(1)) && $stable(page));

    // R2
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == AM_PAGE && col_last) |=> (col == $past(col_start)) && $stable(page));

    // R3
    horz_corner_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == AM_HORZ && col_last && pg_last) |=> (col == $past(col_start)) && (page == $past(page_start)));

    // R4
    vert_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == AM_VERT && !pg_last) |=> (page == $past(page) + PAGE_W'(1)) && $stable(col));

endmodule

// File: rtl/dptr_frame_ram.sv
module dptr_frame_ram #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [ADDR_W-1:0] pix_addr,
    input  logic [2:0]        pix_bit,
    output logic              pix_on
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[addr];
    end

    assign pix_on = mem[pix_addr][pix_bit];

endmodule

// File: rtl/dram_ptr_ctrl.sv
module dram_ptr_ctrl
    import dptr_pkg::*;
#(
    parameter int NUM_COLS  = 128,
    parameter int NUM_PAGES = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cmd_valid,
    input  logic [7:0]                       cmd_byte,
    input  logic                             wr_valid,
    input  logic [7:0]                       wr_byte,
    input  logic                             rd_valid,
    output logic [7:0]                       rd_byte,
    output logic                             ram_we,
    output logic [$clog2(NUM_COLS)+$clog2(NUM_PAGES)-1:0] ram_addr,
    output logic [$clog2(NUM_COLS)-1:0]      col_ptr,
    output logic [$clog2(NUM_PAGES)-1:0]     page_ptr,
    output logic [1:0]                       addr_mode,
    input  logic [$clog2(NUM_PAGES)+2:0]     pix_row,
    input  logic [$clog2(NUM_COLS)-1:0]      pix_col,
    output logic                             pix_on
);

    localparam int COL_W  = $clog2(NUM_COLS);
    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int ADDR_W = COL_W + PAGE_W;
    localparam int ROW_W  = PAGE_W + 3;
    localparam int DEPTH  = NUM_COLS * NUM_PAGES;

    amode_e            mode;
    ptr_req_t          req;
    logic [COL_W-1:0]  col_start, col_end, ld_col_val;
    logic [PAGE_W-1:0] page_start, page_end, ld_pg_val;
    logic              wr_go, rd_go;

    assign wr_go = wr_valid && !cmd_valid;
    assign rd_go = rd_valid && !cmd_valid && !wr_valid;

    dptr_cmd_parser #(
        .COL_W(COL_W), .PAGE_W(PAGE_W),
        .COL_MAX(NUM_COLS - 1), .PAGE_MAX(NUM_PAGES - 1)
    ) u_parser (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .mode(mode),
        .col_start(col_start), .col_end(col_end),
        .page_start(page_start), .page_end(page_end),
        .req(req), .ld_col_val(ld_col_val), .ld_pg_val(ld_pg_val)
    );

    dptr_ptr_unit #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk(clk), .rst(rst), .mode(mode),
        .col_start(col_start), .col_end(col_end),
        .page_start(page_start), .page_end(page_end),
        .req(req), .nib(cmd_byte[3:0]), .pg_sel(cmd_byte[PAGE_W-1:0]),
        .ld_col_val(ld_col_val), .ld_pg_val(ld_pg_val),
        .step(wr_go || rd_go),
        .col(col_ptr), .page(page_ptr)
    );

    dptr_frame_ram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ram (
        .clk(clk), .rst(rst),
        .we(wr_go), .re(rd_go),
        .addr(ram_addr), .wdata(wr_byte), .rdata(rd_byte),
        .pix_addr({pix_row[ROW_W-1:3], pix_col}),
        .pix_bit(pix_row[2:0]),
        .pix_on(pix_on)
    );

    assign ram_addr  = {page_ptr, col_ptr};
    assign ram_we    = wr_go;
    assign addr_mode = mode;

endmodule

// File: tb/sim_dram_ptr_ctrl.sv
module sim_dram_ptr_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid, wr_valid, rd_valid;
    logic [7:0] cmd_byte, wr_byte, rd_byte;
    logic       ram_we;
    logic [9:0] ram_addr;
    logic [6:0] col_ptr, pix_col;
    logic [2:0] page_ptr;
    logic [1:0] addr_mode;
    logic [5:0] pix_row;
    logic       pix_on;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dram_ptr_ctrl u0 (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .wr_valid(wr_valid), .wr_byte(wr_byte),
        .rd_valid(rd_valid), .rd_byte(rd_byte),
        .ram_we(ram_we), .ram_addr(ram_addr),
        .col_ptr(col_ptr), .page_ptr(page_ptr), .addr_mode(addr_mode),
        .pix_row(pix_row), .pix_col(pix_col), .pix_on(pix_on)
    );

    // op: 0 command byte, 1 data write
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] val;
        logic [6:0] ecol;
        logic [2:0] epg;
        logic [1:0] emode;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 8'hB3, 7'd0,   3'd3, 2'd2, 4'd6},   // R6 page set
        '{2'd0, 8'h05, 7'd5,   3'd3, 2'd2, 4'd6},   // R6 low nibble
        '{2'd0, 8'h12, 7'd37,  3'd3, 2'd2, 4'd6},   // R6 high nibble
        '{2'd1, 8'hAA, 7'd38,  3'd3, 2'd2, 4'd9},   // R9 write advances
        '{2'd0, 8'h21, 7'd38,  3'd3, 2'd2, 4'd7},   // R7
        '{2'd0, 8'h7C, 7'd38,  3'd3, 2'd2, 4'd8},   // R8 first arg held
        '{2'd0, 8'h7F, 7'd124, 3'd3, 2'd2, 4'd7},   // R7 load start
        '{2'd1, 8'h01, 7'd125, 3'd3, 2'd2, 4'd2},   // R2
        '{2'd1, 8'h02, 7'd126, 3'd3, 2'd2, 4'd2},
        '{2'd1, 8'h03, 7'd127, 3'd3, 2'd2, 4'd2},
        '{2'd1, 8'h04, 7'd124, 3'd3, 2'd2, 4'd2},   // R2 wrap, page held
        '{2'd0, 8'h20, 7'd124, 3'd3, 2'd2, 4'd5},   // R5
        '{2'd0, 8'h00, 7'd124, 3'd3, 2'd0, 4'd5},   // R5 horizontal
        '{2'd0, 8'h22, 7'd124, 3'd3, 2'd0, 4'd7},   // R7
        '{2'd0, 8'h06, 7'd124, 3'd3, 2'd0, 4'd7},
        '{2'd0, 8'h07, 7'd124, 3'd6, 2'd0, 4'd7},
        '{2'd1, 8'h10, 7'd125, 3'd6, 2'd0, 4'd3},   // R3
        '{2'd1, 8'h11, 7'd126, 3'd6, 2'd0, 4'd3},
        '{2'd1, 8'h12, 7'd127, 3'd6, 2'd0, 4'd3},
        '{2'd1, 8'h13, 7'd124, 3'd7, 2'd0, 4'd3},   // R3 row wrap
        '{2'd1, 8'h14, 7'd125, 3'd7, 2'd0, 4'd3},
        '{2'd1, 8'h15, 7'd126, 3'd7, 2'd0, 4'd3},
        '{2'd1, 8'h16, 7'd127, 3'd7, 2'd0, 4'd3},
        '{2'd1, 8'h17, 7'd124, 3'd6, 2'd0, 4'd3},   // R3 corner wrap
        '{2'd0, 8'h20, 7'd124, 3'd6, 2'd0, 4'd5},
        '{2'd0, 8'h03, 7'd124, 3'd6, 2'd0, 4'd5},   // R5 value 11 kept old
        '{2'd1, 8'h18, 7'd125, 3'd6, 2'd0, 4'd5},
        '{2'd0, 8'h20, 7'd125, 3'd6, 2'd0, 4'd5},
        '{2'd0, 8'h01, 7'd125, 3'd6, 2'd1, 4'd5},   // R5 vertical
        '{2'd1, 8'h19, 7'd125, 3'd7, 2'd1, 4'd4},   // R4
        '{2'd1, 8'h1A, 7'd126, 3'd6, 2'd1, 4'd4},   // R4 page wrap
        '{2'd0, 8'hB2, 7'd126, 3'd6, 2'd1, 4'd6},   // R6 ignored
        '{2'd0, 8'h03, 7'd126, 3'd6, 2'd1, 4'd6},   // R6 ignored
        '{2'd0, 8'h21, 7'd126, 3'd6, 2'd1, 4'd7},
        '{2'd0, 8'h7E, 7'd126, 3'd6, 2'd1, 4'd7},
        '{2'd0, 8'h7F, 7'd126, 3'd6, 2'd1, 4'd7},
        '{2'd1, 8'h1B, 7'd126, 3'd7, 2'd1, 4'd4},   // R4
        '{2'd1, 8'h1C, 7'd127, 3'd6, 2'd1, 4'd4},
        '{2'd1, 8'h1D, 7'd127, 3'd7, 2'd1, 4'd4},
        '{2'd1, 8'h1E, 7'd126, 3'd6, 2'd1, 4'd4},   // R4 corner wrap
        '{2'd0, 8'h20, 7'd126, 3'd6, 2'd1, 4'd5},
        '{2'd0, 8'h02, 7'd126, 3'd6, 2'd2, 4'd5},   // R5 page
        '{2'd0, 8'h21, 7'd126, 3'd6, 2'd2, 4'd8},
        '{2'd0, 8'hB5, 7'd126, 3'd6, 2'd2, 4'd8},   // R8 taken as argument
        '{2'd0, 8'h40, 7'd53,  3'd6, 2'd2, 4'd8},
        '{2'd0, 8'h1F, 7'd117, 3'd6, 2'd2, 4'd6}    // R6 bits 6:4 from 2:0
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmd_valid = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
        cmd_byte = 8'h00; wr_byte = 8'h00;
    endtask

    task automatic apply(input logic [1:0] op, input logic [7:0] val);
        @(negedge clk);
        cmd_valid = (op == 2'd0);
        wr_valid  = (op == 2'd1);
        rd_valid  = (op == 2'd2);
        cmd_byte  = val;
        wr_byte   = val;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        idle_inputs();
        pix_row = '0;
        pix_col = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 col", int'(col_ptr), 0);
        check("R1 page", int'(page_ptr), 0);
        check("R1 mode", int'(addr_mode), 2);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].val);
            if (col_ptr != VEC[i].ecol || page_ptr != VEC[i].epg || addr_mode != VEC[i].emode) begin
                errors++;
                $display("FAIL R%0d step %0d actual col=%0d page=%0d mode=%0d expected col=%0d page=%0d mode=%0d",
                         VEC[i].req, i, col_ptr, page_ptr, addr_mode,
                         VEC[i].ecol, VEC[i].epg, VEC[i].emode);
            end
            checks++;
        end

        // R9 read-back of the byte written at page 3 column 37
        apply(2'd0, 8'hB3);
        apply(2'd0, 8'h05);
        apply(2'd0, 8'h12);
        apply(2'd2, 8'h00);
        check("R9 read data", int'(rd_byte), 8'hAA);
        check("R9 read advance", int'(col_ptr), 38);

        // R10 pixel mapping of AAh at page 3 column 37
        pix_col = 7'd37;
        pix_row = 6'd24; #1 check("R10 top row bit0", int'(pix_on), 0);
        pix_row = 6'd25; #1 check("R10 row bit1", int'(pix_on), 1);
        pix_row = 6'd31; #1 check("R10 bottom row bit7", int'(pix_on), 1);

        // R9 strobe and address in the write cycle
        @(negedge clk);
        wr_valid = 1'b1; wr_byte = 8'h5A;
        #1;
        check("R9 ram_we", int'(ram_we), 1);
        check("R9 ram_addr", int'(ram_addr), 3 * 128 + 38);
        @(negedge clk);
        idle_inputs();
        check("R9 write advance", int'(col_ptr), 39);

        // R11 command wins over a simultaneous write
        @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = 8'hB4;
        wr_valid = 1'b1; wr_byte = 8'hFF;
        #1;
        check("R11 no strobe", int'(ram_we), 0);
        @(negedge clk);
        idle_inputs();
        check("R11 page from command", int'(page_ptr), 4);
        check("R11 column not advanced", int'(col_ptr), 39);

        // R1 reset mid-run restores pointers, mode and full window
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 col after reset", int'(col_ptr), 0);
        check("R1 page after reset", int'(page_ptr), 0);
        check("R1 mode after reset", int'(addr_mode), 2);
        apply(2'd0, 8'h0F);
        apply(2'd0, 8'h17);
        check("R6 column 127", int'(col_ptr), 127);
        apply(2'd1, 8'h00);
        check("R1 default column end wraps to 0", int'(col_ptr), 0);
        check("R2 page held on wrap", int'(page_ptr), 0);

        finish_run();
    end

endmodule